// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flag Register

This block is the arithmetic and flag stage of a small 8-bit datapath. Each accepted operation is a valid strobe, a 4-bit operation code and two operands. On the next clock edge the block registers an 8-bit result and updates a five-flag status register: negative, signed overflow, zero, nibble carry and carry. Carry-using operations take the carry-in from the stored carry flag. Subtraction and subtract-with-borrow report carry and nibble carry as inverted borrows. The two rotates form a nine-bit ring through the carry flag.

Each operation code has a fixed update mask. Flags that the mask leaves out keep their stored values. Logic operations touch only zero and negative, and rotates touch carry, zero and negative. A status-load operation writes the flags directly from operand A. The three upper status bits are unimplemented and always read as zero.

Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 rotate left through carry, 5 rotate right through carry, 6 AND, 7 inclusive OR, 8 exclusive OR, 9 move A, 10 status load. Codes 11 to 15 are undefined.

Top module: `alu_flag_unit`

## Requirements
- R1: The status byte holds C in bit 0, DC in bit 1, Z in bit 2, OV in bit 3 and N in bit 4. Bits 7:5 always read 0. Status load (code 10) copies operand A bits 4:0 into status bits 4:0, ignores operand A bits 7:5, and also places the loaded value, zero-extended, in the result.
- R2: Add (code 0) gives A+B mod 256 and add with carry (code 1) gives A+B+C mod 256. C becomes 1 exactly when the unsigned sum exceeds 255.
- R3: Subtract (code 2) gives A-B mod 256 and subtract with borrow (code 3) gives A-B-(1-C) mod 256. C becomes 1 when no borrow occurs and 0 when a borrow occurs.
- R4: Rotate left (code 4) gives {A[6:0],C} with A[7] going to C. Rotate right (code 5) gives {C,A[7:1]} with A[0] going to C.
- R5: For the four add and subtract codes, OV becomes 1 exactly when the signed two's-complement result lies outside -128..+127.
- R6: For codes 0 to 9, Z becomes 1 exactly when all eight result bits are zero.
- R7: For codes 0 to 9, N equals bit 7 of the result.
- R8: For the four add and subtract codes, DC is the carry out of the low nibble. For subtraction it is the inverted nibble borrow.
- R9: Flags outside an operation's update mask keep their previous value. Codes 6 to 9 update only Z and N. Codes 4 and 5 update only C, Z and N.
- R10: With op_valid low, or with an undefined code 11 to 15, neither the result nor the status changes.
- R11: After reset, the result and the status are both 0.
- R12: The result and the status of an accepted operation appear on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Registered result |
| status | output | 8 | Status register, N OV Z DC C in bits 4..0 |

## Verification
The vector table runs the operations in order, so each step's carry-in comes from the previous step's flags. This shows whether the carry-using codes really read the stored C.

The add vectors cover these cases:
- a nibble-only carry, which separates DC from C;
- a sum that wraps to zero with signed overflow;
- a positive overflow into the sign bit.

The subtract vectors cover these cases:
- equal operands;
- a borrow at the byte level;
- a borrow in the low nibble only;
- a signed overflow from negative minus positive.

These cases expose any polarity error in the inverted-borrow flags. Logic and rotate vectors run with DC left set, which shows that masked flags are held. Directed steps check idle cycles, an undefined code, a status load with ones in the unimplemented bits, and a reset in mid-run.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int FLAG_W = 5;
    localparam int STAT_W = 8;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_ADDC = 4'd1;
    localparam logic [3:0] OP_SUB  = 4'd2;
    localparam logic [3:0] OP_SUBB = 4'd3;
    localparam logic [3:0] OP_RLC  = 4'd4;
    localparam logic [3:0] OP_RRC  = 4'd5;
    localparam logic [3:0] OP_AND  = 4'd6;
    localparam logic [3:0] OP_IOR  = 4'd7;
    localparam logic [3:0] OP_XOR  = 4'd8;
    localparam logic [3:0] OP_MOV  = 4'd9;
    localparam logic [3:0] OP_STWR = 4'd10;

    // Packed so that c is bit 0 and n is bit 4.
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    function automatic flags_t upd_mask(input logic [3:0] op);
        flags_t m;
        m = '0;
        if (op <= OP_SUBB) begin
            m = '1;
        end else if (op == OP_RLC || op == OP_RRC) begin
            m.c = 1'b1;
            m.z = 1'b1;
            m.n = 1'b1;
        end else if (op <= OP_MOV) begin
            m.z = 1'b1;
            m.n = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              dc_out,
    output logic              ov_out
);
    localparam int HALF_W = 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   low;

    // Subtraction adds the complement, so carries come out as inverted borrows.
    always_comb begin
        b_eff  = sub ? ~b : b;
        full   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        low    = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, cin};
        sum    = full[DATA_W-1:0];
        c_out  = full[DATA_W];
        dc_out = low[HALF_W];
        ov_out = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/alu_rotlog.sv
module alu_rotlog #(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    import alu_flag_pkg::*;

    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_RLC: begin
                res   = {a[DATA_W-2:0], cin};
                c_out = a[DATA_W-1];
            end
            OP_RRC: begin
                res   = {cin, a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_AND:  res = a & b;
            OP_IOR:  res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    load,
    input  alu_flag_pkg::flags_t    load_val,
    input  alu_flag_pkg::flags_t    mask,
    input  alu_flag_pkg::flags_t    new_flags,
    output alu_flag_pkg::flags_t    flags_q
);
    import alu_flag_pkg::*;

    logic [FLAG_W-1:0] merged;
    logic [FLAG_W-1:0] cur;

    assign cur = flags_q;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        always_comb begin
            if (load) begin
                merged[i] = load_val[i];
            end else if (mask[i]) begin
                merged[i] = new_flags[i];
            end else begin
                merged[i] = cur[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (we) begin
            flags_q <= merged;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        status
);
    import alu_flag_pkg::*;

    flags_t            flags_q;
    flags_t            new_flags;
    flags_t            load_val;
    logic              is_arith;
    logic              is_sub;
    logic              arith_cin;
    logic              accept;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_c;
    logic              arith_dc;
    logic              arith_ov;
    logic [DATA_W-1:0] rl_res;
    logic              rl_c;
    logic [DATA_W-1:0] res_next;
    logic [DATA_W-1:0] result_q;

    always_comb begin
        is_arith  = (op_code <= OP_SUBB);
        is_sub    = (op_code == OP_SUB) || (op_code == OP_SUBB);
        accept    = op_valid && (op_code <= OP_STWR);
        unique case (op_code)
            OP_ADDC, OP_SUBB: arith_cin = flags_q.c;
            OP_SUB:           arith_cin = 1'b1;
            default:          arith_cin = 1'b0;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a      (opnd_a),
        .b      (opnd_b),
        .sub    (is_sub),
        .cin    (arith_cin),
        .sum    (arith_sum),
        .c_out  (arith_c),
        .dc_out (arith_dc),
        .ov_out (arith_ov)
    );

    alu_rotlog #(.DATA_W(DATA_W)) rotlog_i (
        .op    (op_code),
        .a     (opnd_a),
        .b     (opnd_b),
        .cin   (flags_q.c),
        .res   (rl_res),
        .c_out (rl_c)
    );

    always_comb begin
        load_val = flags_t'(opnd_a[FLAG_W-1:0]);
        if (op_code == OP_STWR) begin
            res_next = DATA_W'(opnd_a[FLAG_W-1:0]);
        end else if (is_arith) begin
            res_next = arith_sum;
        end else begin
            res_next = rl_res;
        end
        new_flags.n  = res_next[DATA_W-1];
        new_flags.z  = (res_next == '0);
        new_flags.ov = arith_ov;
        new_flags.dc = arith_dc;
        new_flags.c  = is_arith ? arith_c : rl_c;
    end

    alu_status_reg status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (accept),
        .load      (op_code == OP_STWR),
        .load_val  (load_val),
        .mask      (upd_mask(op_code)),
        .new_flags (new_flags),
        .flags_q   (flags_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (accept) begin
            result_q <= res_next;
        end
    end

    assign result = result_q;
    assign status = {{(STAT_W-FLAG_W){1'b0}}, flags_q};
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] result,
    input logic [7:0]        status
);
    // R6
    a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd9) |=> (status[2] == (result == '0)));

    // R7
    a_r7_neg_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd9) |=> (status[4] == result[DATA_W-1]));

    // R9
    a_r9_logic_holds_c_dc_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd6 && op_code <= 4'd9)
        |=> (status[1:0] == $past(status[1:0])) && (status[3] == $past(status[3])));

    // R10
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 4'd10) |=> ($stable(status) && $stable(result)));

    // R2
    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0)
        |=> (status[0] == (({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) > (DATA_W+1)'((1 << DATA_W) - 1))));

    // R3
    a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=> (status[0] == ($past(opnd_a) >= $past(opnd_b))));

    // R4
    a_r4_rotate_left_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd4)
        |=> (status[0] == $past(opnd_a[DATA_W-1])) && (result[0] == $past(status[0])));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .status   (status)
);

// File: tb/alu_flag_unit_tb_top.sv
module alu_flag_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic [7:0] status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2ns clk = ~clk;

    alu_flag_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .status   (status)
    );

    // Each entry: op, A, B, expected result, expected status. Applied in order.
    localparam int NV = 20;
    localparam logic [35:0] VEC [NV] = '{
        {4'd10, 8'hFF, 8'h00, 8'h1F, 8'h1F},   // R1 load, upper bits dropped
        {4'd0,  8'h0F, 8'h01, 8'h10, 8'h02},   // R8 nibble carry only
        {4'd0,  8'h80, 8'h80, 8'h00, 8'h0D},   // R2 R5 R6 wrap, overflow
        {4'd1,  8'h01, 8'h01, 8'h03, 8'h00},   // R2 carry-in used
        {4'd0,  8'h7F, 8'h01, 8'h80, 8'h1A},   // R5 R7 positive overflow
        {4'd2,  8'h05, 8'h03, 8'h02, 8'h03},   // R3 no borrow
        {4'd2,  8'h03, 8'h05, 8'hFE, 8'h10},   // R3 borrow
        {4'd3,  8'h10, 8'h01, 8'h0E, 8'h01},   // R3 R8 borrow-in, nibble borrow
        {4'd2,  8'h80, 8'h01, 8'h7F, 8'h09},   // R5 negative minus positive
        {4'd2,  8'h42, 8'h42, 8'h00, 8'h07},   // R6 R8 equal operands
        {4'd6,  8'hF0, 8'h0F, 8'h00, 8'h07},   // R9 AND
        {4'd7,  8'h80, 8'h01, 8'h81, 8'h13},   // R9 IOR
        {4'd8,  8'hFF, 8'hFF, 8'h00, 8'h07},   // R9 XOR
        {4'd4,  8'h81, 8'h00, 8'h03, 8'h03},   // R4 rotate left
        {4'd5,  8'h02, 8'h00, 8'h81, 8'h12},   // R4 rotate right
        {4'd4,  8'h00, 8'h00, 8'h00, 8'h06},   // R4 zero ring
        {4'd9,  8'h9C, 8'h00, 8'h9C, 8'h12},   // R9 move
        {4'd12, 8'h55, 8'h00, 8'h9C, 8'h12},   // R10 undefined code
        {4'd10, 8'hE0, 8'h00, 8'h00, 8'h00},   // R1 load with only upper ones
        {4'd1,  8'hFF, 8'h00, 8'hFF, 8'h10}    // R2 carry-in clear
    };

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd1)  return "R2/R5/R6/R7/R8/R12";
        if (op <= 4'd3)  return "R3/R5/R6/R7/R8/R12";
        if (op <= 4'd5)  return "R4/R6/R7/R9";
        if (op <= 4'd9)  return "R9/R6/R7";
        if (op == 4'd10) return "R1";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_valid = v;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "reset result", result, 8'h00);
        check("R11", "reset status", status, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][35:32], VEC[i][31:24], VEC[i][23:16]);
            check(tag_of(VEC[i][35:32]), $sformatf("vec %0d result", i), result, VEC[i][15:8]);
            check(tag_of(VEC[i][35:32]), $sformatf("vec %0d status", i), status, VEC[i][7:0]);
        end

        // R10: inputs present but no strobe
        apply(1'b0, 4'd0, 8'hFF, 8'hFF);
        check("R10", "idle result", result, 8'hFF);
        check("R10", "idle status", status, 8'h10);

        // R1: status load with all ones reads back with bits 7:5 clear
        apply(1'b1, 4'd10, 8'hFF, 8'h00);
        check("R1", "unimplemented bits", status & 8'hE0, 8'h00);

        // R3: subtract with borrow when C is set uses no extra borrow
        apply(1'b1, 4'd3, 8'h20, 8'h10);
        check("R3", "subb carry set result", result, 8'h10);
        check("R3", "subb carry set status", status, 8'h03);

        // R11: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "mid reset result", result, 8'h00);
        check("R11", "mid reset status", status, 8'h00);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4ns);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule